// File: doc/BRIEF.md
# Relocatable Inverting GPIO Port

An eight-pin general-purpose I/O port run from a small configuration register file. Each pin has a direction bit and a polarity bit. The polarity bit flips the value driven onto the pin and also the value sampled from it. The data register is writable only for pins set as outputs. Reading it returns the stored value for output pins and the synchronized, polarity-corrected pin level for input pins.

One synchronous register bus carries both the configuration registers and a relocatable I/O window. A space-select input picks which of the two an access targets. Software places the window on any 4-byte-aligned address from 0x100 to 0xFFF, and the data register then appears at offset 0 of that window. The window responds, and the pins are driven, only while the port's activation bit is set. The configuration registers stay reachable at all times.

Top module: `gpio_window_port`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge): the direction register is 0xFF, the data, inversion, activation and both base registers are 0x00, pin_oe is 0x00 and bus_rdata is 0x00.
- R2: A direction bit of 1 makes that pin an input, with pin_oe low. A bit of 0 makes it an output, with pin_oe high while the port is active.
- R3: Output pins take written data bits. Reading the data register returns those stored bits, and pin_out equals the data register XOR the inversion register.
- R4: Data writes leave the stored bit of an input pin unchanged. For an input pin, a data read returns the synchronized pin level XOR its inversion bit.
- R5: An inversion bit of 1 inverts both the driven value and the read-in value of its pin. A bit of 0 passes both unchanged.
- R6: Configuration index 0x00 is the activation register. Bit 0 enables the port, and bits 7..1 read as zero.
- R7: Configuration index 0x01 holds base bits 15..8 and index 0x02 holds base bits 7..0. Base bits 1..0 are stored as zero whatever is written.
- R8: With bus_io_sel=1, the data register answers reads and writes at the base address, offset 0. This requires the port to be active and the base to lie in 0x100..0xFFF. Any other base disables the window.
- R9: While inactive, pin_oe is 0x00 and window accesses read 0x00 and write nothing. Configuration accesses still work.
- R10: pin_in passes through two flops. A level applied before a rising edge becomes visible to a data read issued two edges later.
- R11: Unmapped addresses read 0x00 and ignore writes. This covers window offsets 1 to 3, configuration indices other than 0x00, 0x01, 0x02, 0x04 (direction), 0x05 (data) and 0x06 (inversion), and configuration accesses with bus_addr[15:8] non-zero.
- R12: bus_rdata is registered. It holds the read value in the cycle after a bus_rd edge and is 0x00 in the cycle after any edge without bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_io_sel | input | 1 | 1 = I/O window space, 0 = configuration space |
| bus_addr | input | 16 | Access address (configuration index in bits 7..0) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels sampled from the pads |
| pin_out | output | 8 | Values driven to the pads |
| pin_oe | output | 8 | Per-pin output enables |

## Verification
The bench sweeps mixed direction and inversion masks against many data words. This would expose a design that lets input-pin writes land in the register, or that applies inversion to output readback instead of only to the pins. It relocates the window across the bottom, middle and top of the legal range and just outside it. A decoder that ignores the range limits, or that fails to clear the low base bits, would then answer at the wrong address. It also checks that deactivating the port silences both the window and the enables, and that a pin change needs exactly two edges before a read sees it.

// File: rtl/gpio_win_pkg.sv
// Shared constants for the relocatable GPIO port: configuration indices
// and the legal window range. Assumes an 8-bit configuration index space.
package gpio_win_pkg;
    localparam logic [7:0]  CFG_ACT     = 8'h00;
    localparam logic [7:0]  CFG_BASE_HI = 8'h01;
    localparam logic [7:0]  CFG_BASE_LO = 8'h02;
    localparam logic [7:0]  CFG_DIR     = 8'h04;
    localparam logic [7:0]  CFG_DATA    = 8'h05;
    localparam logic [7:0]  CFG_INV     = 8'h06;
    localparam logic [15:0] WIN_MIN     = 16'h0100;
    localparam logic [15:0] WIN_MAX     = 16'h0FFF;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-flop synchronizer for the pin inputs. Assumes pins are
// asynchronous and each bit may be resolved independently.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage retimes the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
// Per-pin datapath: applies polarity on the way out and in, gates the
// output enables with activation, and forms the data-register read view.
// Assumes dir bit 1 = input.
module gpio_pin_drive #(
    parameter int WIDTH = 8
) (
    input  logic             active,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] inv,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] read_view
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            assign pin_out[i]   = data[i] ^ inv[i];
            assign pin_oe[i]    = active & ~dir[i];
            assign read_view[i] = dir[i] ? (pin_sync[i] ^ inv[i]) : data[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_cfg_regs.sv
// Configuration register file and I/O window decoder on a synchronous
// strobe bus. Read data is registered one cycle after the strobe.
// Assumes at most one of bus_wr / bus_rd per cycle.
module gpio_cfg_regs
    import gpio_win_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_io_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [WIDTH-1:0]  read_view,
    output logic              act_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  inv_q
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0]        base_hi_q;
    logic [7:0]        base_lo_q;
    logic [ADDR_W-1:0] base;
    logic              base_ok;
    logic              cfg_hit;
    logic              win_data;
    logic              data_sel;
    logic [7:0]        idx;
    logic [7:0]        rd_mux;

    assign idx      = bus_addr[7:0];
    assign cfg_hit  = !bus_io_sel && (bus_addr[ADDR_W-1:8] == '0);
    assign base     = ADDR_W'({base_hi_q, base_lo_q});
    assign base_ok  = (base >= ADDR_W'(WIN_MIN)) && (base <= ADDR_W'(WIN_MAX));
    assign win_data = bus_io_sel && act_q && base_ok && (bus_addr == base);
    assign data_sel = (cfg_hit && idx == CFG_DATA) || win_data;

    // Configuration register writes other than data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            base_hi_q <= '0;
            base_lo_q <= '0;
            dir_q     <= '1;
            inv_q     <= '0;
        end else if (bus_wr && cfg_hit) begin
            case (idx)
                CFG_ACT:     act_q     <= bus_wdata[0];
                CFG_BASE_HI: base_hi_q <= bus_wdata;
                CFG_BASE_LO: base_lo_q <= {bus_wdata[7:2], 2'b00};
                CFG_DIR:     dir_q     <= bus_wdata[WIDTH-1:0];
                CFG_INV:     inv_q     <= bus_wdata[WIDTH-1:0];
                default:     ;
            endcase
        end
    end

    // Data register: only output-pin bits accept new values.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (bus_wr && data_sel)
            data_q <= (data_q & dir_q) | (bus_wdata[WIDTH-1:0] & ~dir_q);
    end

    // Read multiplexer; unmapped addresses yield zero.
    always_comb begin
        rd_mux = 8'h00;
        if (data_sel) rd_mux = 8'(read_view);
        else if (cfg_hit) begin
            case (idx)
                CFG_ACT:     rd_mux = {7'b0, act_q};
                CFG_BASE_HI: rd_mux = base_hi_q;
                CFG_BASE_LO: rd_mux = base_lo_q;
                CFG_DIR:     rd_mux = 8'(dir_q);
                CFG_INV:     rd_mux = 8'(inv_q);
                default:     rd_mux = 8'h00;
            endcase
        end
    end

    // Registered read data, cleared when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= 8'h00;
        else        bus_rdata <= bus_rd ? rd_mux : 8'h00;
    end

    assert_input_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && data_sel) |=> ((data_q & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    assert_window_silent_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_io_sel && !act_q) |=> (bus_rdata == 8'h00));

    assert_rdata_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 8'h00));

    logic unused_hi;
    assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/gpio_window_port.sv
// Top of the relocatable GPIO port: register file, input synchronizer
// and per-pin drive logic. Assumes pads take pin_out when pin_oe is high.
module gpio_window_port #(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_io_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    logic             act;
    logic [WIDTH-1:0] dir, data, inv, pin_sync, read_view;

    gpio_cfg_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_io_sel(bus_io_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .read_view(read_view), .act_q(act),
        .dir_q(dir), .data_q(data), .inv_q(inv)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_pin_drive #(.WIDTH(WIDTH)) u_drive (
        .active(act), .dir(dir), .data(data), .inv(inv), .pin_sync(pin_sync),
        .pin_out(pin_out), .pin_oe(pin_oe), .read_view(read_view)
    );

    assert_oe_off_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (pin_oe == '0));

    assert_oe_matches_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> ((pin_oe & dir) == '0));
endmodule

// File: tb/gpio_window_port_bench.sv
module gpio_window_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        bus_io_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_addr = 0;
    logic [7:0]  bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_window_port u_gpio_window_port (
        .clk(clk), .rst_n(rst_n), .bus_io_sel(bus_io_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wr(bit io, logic [15:0] a, logic [7:0] d);
        bus_io_sel = io; bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1; bus_wr = 0;
    endtask

    task automatic rd(bit io, logic [15:0] a, output logic [7:0] d);
        bus_io_sel = io; bus_addr = a; bus_rd = 1;
        @(posedge clk); #1; bus_rd = 0; d = bus_rdata;
    endtask

    initial begin
        logic [7:0] r, model, dirv, invv, w;
        logic [15:0] bases [3];
        bases[0] = 16'h0100; bases[1] = 16'h02F4; bases[2] = 16'h0FFC;
        repeat (3) @(posedge clk); #1; rst_n = 1;
        // R1 reset values
        chk("R1 oe", pin_oe, 8'h00); chk("R1 rdata", bus_rdata, 8'h00);
        rd(0, 16'h0004, r); chk("R1 dir", r, 8'hFF);
        rd(0, 16'h0006, r); chk("R1 inv", r, 8'h00);
        rd(0, 16'h0000, r); chk("R1 act", r, 8'h00);
        rd(0, 16'h0001, r); chk("R1 base_hi", r, 8'h00);
        rd(0, 16'h0002, r); chk("R1 base_lo", r, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        // R6 activation register
        wr(0, 16'h0000, 8'hFF); rd(0, 16'h0000, r); chk("R6 act rd", r, 8'h01);
        wr(0, 16'h0000, 8'hFE); rd(0, 16'h0000, r); chk("R6 act clr", r, 8'h00);
        // R7 base registers
        wr(0, 16'h0002, 8'h07); rd(0, 16'h0002, r); chk("R7 lo align", r, 8'h04);
        wr(0, 16'h0001, 8'h03); rd(0, 16'h0001, r); chk("R7 hi", r, 8'h03);
        // R9 inactive: config works, window silent, oe off
        wr(0, 16'h0004, 8'h00); chk("R9 oe inactive", pin_oe, 8'h00);
        rd(1, 16'h0304, r); chk("R9 window silent", r, 8'h00);
        wr(1, 16'h0304, 8'hAA); rd(0, 16'h0005, r); chk("R9 window no write", r, 8'h00);
        wr(0, 16'h0000, 8'h01);
        model = 8'h00;
        // R2 R3 R4 R5 R8 sweep
        for (int b = 0; b < 3; b++) begin
            wr(0, 16'h0001, bases[b][15:8]); wr(0, 16'h0002, bases[b][7:0]);
            for (int iv = 0; iv < 4; iv++) begin
                invv = (iv == 0) ? 8'h00 : (iv == 1) ? 8'hFF : (iv == 2) ? 8'hA5 : 8'h3C;
                wr(0, 16'h0006, invv);
                for (int dv = 0; dv < 4; dv++) begin
                    dirv = (dv == 0) ? 8'h00 : (dv == 1) ? 8'hFF : (dv == 2) ? 8'h0F : 8'h96;
                    wr(0, 16'h0004, dirv);
                    chk("R2 oe", pin_oe, ~dirv);
                    for (int k = 0; k < 16; k++) begin
                        w = 8'(k * 17 + b * 3);
                        pin_in = w ^ 8'h5A;
                        wr(1, bases[b], w);
                        model = (model & dirv) | (w & ~dirv);
                        chk("R3 R5 pin_out", pin_out, model ^ invv);
                        @(posedge clk); #1;
                        rd(1, bases[b], r);
                        chk("R4 R8 window rd", r, (model & ~dirv) | ((pin_in ^ invv) & dirv));
                    end
                    rd(0, 16'h0005, r);
                    chk("R3 cfg data rd", r, (model & ~dirv) | ((pin_in ^ invv) & dirv));
                    for (int o = 1; o < 4; o++) begin
                        rd(1, bases[b] + 16'(o), r); chk("R11 offset rd", r, 8'h00);
                    end
                end
            end
        end
        // R11 unmapped writes/reads
        wr(0, 16'h0006, 8'h00); wr(0, 16'h0004, 8'h00); wr(0, 16'h0005, 8'h33);
        wr(1, 16'h0FFD, 8'hCC); wr(0, 16'h0105, 8'hCC); wr(0, 16'h0003, 8'hCC);
        rd(0, 16'h0005, r); chk("R11 no write", r, 8'h33);
        rd(0, 16'h0003, r); chk("R11 unmapped rd", r, 8'h00);
        rd(0, 16'h0105, r); chk("R11 high cfg rd", r, 8'h00);
        // R8 out-of-range bases
        wr(0, 16'h0001, 8'h00); wr(0, 16'h0002, 8'hFC);
        rd(1, 16'h00FC, r); chk("R8 below range", r, 8'h00);
        wr(0, 16'h0001, 8'h10); wr(0, 16'h0002, 8'h00);
        rd(1, 16'h1000, r); chk("R8 above range", r, 8'h00);
        wr(1, 16'h1000, 8'h11); rd(0, 16'h0005, r); chk("R8 no write", r, 8'h33);
        // R10 two-flop latency
        wr(0, 16'h0004, 8'hFF); pin_in = 8'h00; repeat (3) @(posedge clk); #1;
        pin_in = 8'hC3; @(posedge clk); #1;
        rd(0, 16'h0005, r); chk("R10 too early", r, 8'h00);
        rd(0, 16'h0005, r); chk("R10 after two", r, 8'hC3);
        // R12 idle rdata
        @(posedge clk); #1; chk("R12 idle", bus_rdata, 8'h00);
        // R9 deactivate drops oe
        wr(0, 16'h0004, 8'h00); chk("R2 active oe", pin_oe, 8'hFF);
        wr(0, 16'h0000, 8'h00); chk("R9 deact oe", pin_oe, 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule